// File: doc/BRIEF.md
# Sample-Clocked Pulse Train Generator

This block produces a digital pulse train whose timing is measured in ticks of a source-clock enable (`src_tick`). All logic runs on a single system clock. Every phase of the output is timed by one shared down-counter. The counter is loaded with a tick count and runs to zero before the next phase count is loaded.

In continuous mode the output alternates between a programmed low width and a programmed high width. With widths of L and H ticks, the output frequency is the tick rate divided by (L+H). In buffered mode the block waits for a sample clock. On each one it takes the next (idle, active) tick pair from a small write FIFO and plays one low phase followed by one high phase. An optional initial delay follows the start trigger in both modes.

Generation begins only after the block is armed and a start trigger has been seen. It can be paused with a gate input. It can also stop by itself after a set number of pulses, marking the end with a one-cycle done pulse.

Top module: `pulse_train_gen`

## Requirements
- R1: After reset, and while `arm` is low, `pulse_out`, `done` and `underrun` are 0, and `wr_full` is 0 after reset.
- R2: Once armed, nothing happens until `start_trig` is seen; ticks given before the trigger leave `pulse_out` low.
- R3: In continuous mode, counting effective ticks after the trigger, the output is low for `low_ticks` ticks and then high for `high_ticks` ticks, repeating; a count of 0 behaves as 1.
- R4: `delay_ticks` effective ticks of low output come between the trigger and the first low phase in both modes; a value of 0 means no delay.
- R5: Only cycles with `src_tick` high advance timing. While `pause_en` and `gate` are both high, ticks are ignored and the output holds. With `pause_en` low, `gate` has no effect.
- R6: With `finite_mode` high, the block stops after `pulse_limit` (at least 1) completed high phases. It then keeps the output low. `done` is high for exactly one cycle, in the cycle where the last high phase ends.
- R7: In buffered mode, after the delay, a `samp_clk` seen while the block is waiting pops one pair from the FIFO. The output is then low for the idle count and high for the active count, after which the block waits again. Sample clocks during the delay or during a pair are ignored.
- R8: A `samp_clk` seen while waiting with an empty FIFO sets `underrun`. The flag stays set until `arm` goes low, and the output stays low.
- R9: The FIFO holds DEPTH pairs (4 by default), presented on `wr_idle` and `wr_active` and written when `wr_en` is high. `wr_full` is high when it holds DEPTH pairs, and a write while full is dropped.
- R10: Dropping `arm` drives `pulse_out` low from the next cycle on. The block then needs a new arm and a new trigger to run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Level enable; low disarms and clears state |
| buffered_mode | input | 1 | 1 selects FIFO-driven samples, 0 continuous |
| finite_mode | input | 1 | 1 stops after `pulse_limit` pulses |
| pulse_limit | input | NUM_W | Number of pulses or samples in finite mode |
| low_ticks | input | CNT_W | Continuous low width in ticks |
| high_ticks | input | CNT_W | Continuous high width in ticks |
| delay_ticks | input | CNT_W | Initial delay in ticks |
| pause_en | input | 1 | Lets `gate` pause the generation |
| src_tick | input | 1 | Source-clock enable, one cycle per tick |
| samp_clk | input | 1 | Sample clock pulse for buffered mode |
| start_trig | input | 1 | Start trigger |
| gate | input | 1 | Pause gate, active high |
| wr_en | input | 1 | FIFO write strobe |
| wr_idle | input | CNT_W | Idle tick count of the written pair |
| wr_active | input | CNT_W | Active tick count of the written pair |
| wr_full | output | 1 | FIFO full |
| done | output | 1 | One-cycle pulse at the end of a finite run |
| underrun | output | 1 | Sticky empty-FIFO sample flag |
| pulse_out | output | 1 | Generated pulse train |

## Verification
The assertions check the following on every cycle. Disarming silences the output, and `done` lasts one cycle with the output low. `underrun` is sticky, is cleared by disarm, and only rises after a sample clock. The output cannot move while a pause is in force. The exact position of each edge cannot be judged locally; only the bench scenarios show it. The bench sweeps delay, low and high widths under several tick and gate patterns, and compares every cycle against a tick-count formula. It also checks finite stop counts, the popping of FIFO pairs under sample clocks that arrive both early and on time, and the full and underrun boundaries.

// File: rtl/ptg_pkg.sv
`timescale 1ns/1ps
package ptg_pkg;
   typedef enum logic [2:0] {
      ST_OFF,
      ST_ARMED,
      ST_DELAY,
      ST_IDLE,
      ST_ACTIVE,
      ST_WAITSMP,
      ST_DONE
   } ptg_state_e;
endpackage

// File: rtl/ptg_fifo.sv
`timescale 1ns/1ps
module ptg_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head_data,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [AW:0]   fill;
   logic          do_push, do_pop;

   assign empty     = (fill == '0);
   assign full      = (fill == (AW+1)'(DEPTH));
   assign do_push   = push && !full;
   assign do_pop    = pop && !empty;
   assign head_data = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         if (do_push && !do_pop)      fill <= fill + 1'b1;
         else if (do_pop && !do_push) fill <= fill - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/ptg_phase_timer.sv
`timescale 1ns/1ps
module ptg_phase_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   output logic             expire
);
   logic [CNT_W-1:0] remain;

   assign expire = tick && (remain == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= (load_val == '0) ? '0 : load_val - CNT_W'(1);
      else if (tick && remain != '0)
         remain <= remain - CNT_W'(1);
   end
endmodule

// File: rtl/ptg_seq.sv
`timescale 1ns/1ps
module ptg_seq
   import ptg_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int NUM_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             buffered_mode,
   input  logic             finite_mode,
   input  logic [NUM_W-1:0] pulse_limit,
   input  logic [CNT_W-1:0] low_ticks,
   input  logic [CNT_W-1:0] high_ticks,
   input  logic [CNT_W-1:0] delay_ticks,
   input  logic             start_trig,
   input  logic             samp_clk,
   input  logic             expire,
   input  logic             q_empty,
   input  logic [CNT_W-1:0] q_idle,
   input  logic [CNT_W-1:0] q_active,
   output logic             t_load,
   output logic [CNT_W-1:0] t_val,
   output logic             q_pop,
   output logic             pulse_out,
   output logic             done,
   output logic             underrun
);
   ptg_state_e       st, st_nxt;
   logic [CNT_W-1:0] act_hold;
   logic [NUM_W-1:0] pulses;
   logic             last_pulse, set_ur, finish, pulse_end;

   assign last_pulse = ({1'b0, pulses} + (NUM_W+1)'(1)) >= {1'b0, pulse_limit};

   always_comb begin
      st_nxt    = st;
      t_load    = 1'b0;
      t_val     = '0;
      q_pop     = 1'b0;
      set_ur    = 1'b0;
      finish    = 1'b0;
      pulse_end = 1'b0;
      unique case (st)
         ST_OFF:   if (arm) st_nxt = ST_ARMED;
         ST_ARMED: if (start_trig) begin
            if (delay_ticks != '0) begin
               st_nxt = ST_DELAY; t_load = 1'b1; t_val = delay_ticks;
            end else if (buffered_mode) begin
               st_nxt = ST_WAITSMP;
            end else begin
               st_nxt = ST_IDLE; t_load = 1'b1; t_val = low_ticks;
            end
         end
         ST_DELAY: if (expire) begin
            if (buffered_mode) st_nxt = ST_WAITSMP;
            else begin st_nxt = ST_IDLE; t_load = 1'b1; t_val = low_ticks; end
         end
         ST_WAITSMP: if (samp_clk) begin
            if (!q_empty) begin
               q_pop = 1'b1; st_nxt = ST_IDLE; t_load = 1'b1; t_val = q_idle;
            end else set_ur = 1'b1;
         end
         ST_IDLE: if (expire) begin
            st_nxt = ST_ACTIVE; t_load = 1'b1;
            t_val  = buffered_mode ? act_hold : high_ticks;
         end
         ST_ACTIVE: if (expire) begin
            pulse_end = 1'b1;
            if (finite_mode && last_pulse) begin
               st_nxt = ST_DONE; finish = 1'b1;
            end else if (buffered_mode) st_nxt = ST_WAITSMP;
            else begin st_nxt = ST_IDLE; t_load = 1'b1; t_val = low_ticks; end
         end
         ST_DONE: st_nxt = ST_DONE;
         default: st_nxt = ST_OFF;
      endcase
      if (!arm) begin
         st_nxt = ST_OFF; t_load = 1'b0; q_pop = 1'b0;
         set_ur = 1'b0; finish = 1'b0; pulse_end = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         act_hold <= '0;
         pulses   <= '0;
         done     <= 1'b0;
         underrun <= 1'b0;
      end else begin
         st   <= st_nxt;
         done <= finish;
         if (q_pop) act_hold <= q_active;
         if (!arm)           pulses <= '0;
         else if (pulse_end) pulses <= pulses + 1'b1;
         if (!arm)        underrun <= 1'b0;
         else if (set_ur) underrun <= 1'b1;
      end
   end

   assign pulse_out = (st == ST_ACTIVE);
endmodule

// File: rtl/pulse_train_gen.sv
`timescale 1ns/1ps
module pulse_train_gen #(
   parameter int CNT_W = 8,
   parameter int NUM_W = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             buffered_mode,
   input  logic             finite_mode,
   input  logic [NUM_W-1:0] pulse_limit,
   input  logic [CNT_W-1:0] low_ticks,
   input  logic [CNT_W-1:0] high_ticks,
   input  logic [CNT_W-1:0] delay_ticks,
   input  logic             pause_en,
   input  logic             src_tick,
   input  logic             samp_clk,
   input  logic             start_trig,
   input  logic             gate,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_idle,
   input  logic [CNT_W-1:0] wr_active,
   output logic             wr_full,
   output logic             done,
   output logic             underrun,
   output logic             pulse_out
);
   localparam int PAIR_W = 2 * CNT_W;

   if (CNT_W < 2) begin : g_chk_cnt
      $error("CNT_W must be at least 2");
   end
   if (NUM_W < 1) begin : g_chk_num
      $error("NUM_W must be at least 1");
   end
   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
      $error("DEPTH must be a power of two, at least 2");
   end

   logic              eff_tick, expire, t_load, q_pop, q_empty;
   logic [CNT_W-1:0]  t_val;
   logic [PAIR_W-1:0] q_head;

   assign eff_tick = src_tick && !(pause_en && gate);

   ptg_fifo #(.W(PAIR_W), .DEPTH(DEPTH)) i_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (wr_en),
      .push_data ({wr_idle, wr_active}),
      .pop       (q_pop),
      .head_data (q_head),
      .empty     (q_empty),
      .full      (wr_full)
   );

   ptg_phase_timer #(.CNT_W(CNT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .tick     (eff_tick),
      .expire   (expire)
   );

   ptg_seq #(.CNT_W(CNT_W), .NUM_W(NUM_W)) i_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .arm           (arm),
      .buffered_mode (buffered_mode),
      .finite_mode   (finite_mode),
      .pulse_limit   (pulse_limit),
      .low_ticks     (low_ticks),
      .high_ticks    (high_ticks),
      .delay_ticks   (delay_ticks),
      .start_trig    (start_trig),
      .samp_clk      (samp_clk),
      .expire        (expire),
      .q_empty       (q_empty),
      .q_idle        (q_head[PAIR_W-1:CNT_W]),
      .q_active      (q_head[CNT_W-1:0]),
      .t_load        (t_load),
      .t_val         (t_val),
      .q_pop         (q_pop),
      .pulse_out     (pulse_out),
      .done          (done),
      .underrun      (underrun)
   );
endmodule

// File: rtl/ptg_chk.sv
`timescale 1ns/1ps
module ptg_chk (
   input logic clk,
   input logic rst_n,
   input logic arm,
   input logic gate,
   input logic pause_en,
   input logic samp_clk,
   input logic done,
   input logic underrun,
   input logic pulse_out
);
   // R10
   disarm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !pulse_out);
   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6
   done_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !pulse_out);
   // R8
   underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && arm) |=> underrun);
   // R8
   underrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arm |=> !underrun);
   // R8
   underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(underrun) |-> $past(samp_clk));
   // R5
   pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_en && gate && arm) |=> $stable(pulse_out));
endmodule

bind pulse_train_gen ptg_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .arm       (arm),
   .gate      (gate),
   .pause_en  (pause_en),
   .samp_clk  (samp_clk),
   .done      (done),
   .underrun  (underrun),
   .pulse_out (pulse_out)
);

// File: tb/test_pulse_train_gen.sv
`timescale 1ns/1ps
module test_pulse_train_gen;
   localparam int CNT_W = 8;
   localparam int NUM_W = 8;
   localparam int DEPTH = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic arm = 0, buffered_mode = 0, finite_mode = 0, pause_en = 0;
   logic src_tick = 0, samp_clk = 0, start_trig = 0, gate = 0, wr_en = 0;
   logic [NUM_W-1:0] pulse_limit = '0;
   logic [CNT_W-1:0] low_ticks = '0, high_ticks = '0, delay_ticks = '0;
   logic [CNT_W-1:0] wr_idle = '0, wr_active = '0;
   logic wr_full, done, underrun, pulse_out;

   int total = 0;
   int bad = 0;
   int edge_no = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) edge_no <= edge_no + 1;

   pulse_train_gen #(.CNT_W(CNT_W), .NUM_W(NUM_W), .DEPTH(DEPTH)) i_pulse_train_gen (
      .clk(clk), .rst_n(rst_n), .arm(arm), .buffered_mode(buffered_mode),
      .finite_mode(finite_mode), .pulse_limit(pulse_limit), .low_ticks(low_ticks),
      .high_ticks(high_ticks), .delay_ticks(delay_ticks), .pause_en(pause_en),
      .src_tick(src_tick), .samp_clk(samp_clk), .start_trig(start_trig), .gate(gate),
      .wr_en(wr_en), .wr_idle(wr_idle), .wr_active(wr_active), .wr_full(wr_full),
      .done(done), .underrun(underrun), .pulse_out(pulse_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at edge %0d", req, act, exp, edge_no);
      end
   endtask

   function automatic int level(int n, int d, int lp, int hp, bit fin, int lim);
      int m;
      if (n < d + lp) return 0;
      m = n - d - lp;
      if (fin && (m / (lp + hp)) >= lim) return 0;
      return ((m % (lp + hp)) < hp) ? 1 : 0;
   endfunction

   task automatic run_cont(input int d, input int l, input int h, input bit fin,
                           input int lim, input int pat, input int cycles);
      int n, nprev, lp, hp, nend;
      bit tk, gt, pen;
      lp = (l == 0) ? 1 : l;
      hp = (h == 0) ? 1 : h;
      nend = d + lim * (lp + hp);
      arm = 0; start_trig = 0; src_tick = 0; gate = 0;
      @(negedge clk);
      buffered_mode = 0; finite_mode = fin; pulse_limit = NUM_W'(lim);
      low_ticks = CNT_W'(l); high_ticks = CNT_W'(h); delay_ticks = CNT_W'(d);
      pause_en = (pat != 3);
      arm = 1;
      @(negedge clk);
      start_trig = 1; src_tick = 1;
      @(negedge clk);
      start_trig = 0;
      n = 0; nprev = 0;
      chk("R4 low after trigger", pulse_out, 0);
      for (int c = 0; c < cycles; c++) begin
         case (pat)
            0: begin tk = 1; gt = 0; pen = 1; end
            1: begin tk = (c % 3 != 1); gt = (c % 7 >= 5); pen = 1; end
            2: begin tk = 1; gt = ((c / 4) % 3 == 0); pen = 1; end
            default: begin tk = 1; gt = 1; pen = 0; end
         endcase
         src_tick = tk; gate = gt; pause_en = pen;
         @(negedge clk);
         if (tk && !(pen && gt)) n++;
         chk(fin ? "R6 finite waveform" : "R3 R4 R5 waveform", pulse_out,
             level(n, d, lp, hp, fin, lim));
         chk("R6 done timing", done, (fin && n == nend && nprev == nend - 1) ? 1 : 0);
         nprev = n;
      end
      chk("R8 no underrun in continuous mode", underrun, 0);
      gate = 0; src_tick = 0;
   endtask

   int qi[5], qa[5];
   int head, qcnt, e0, hs, he;
   bit ur_exp, sp;

   initial begin
      #80000;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", edge_no);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pulse_out after reset", pulse_out, 0);
      chk("R1 done after reset", done, 0);
      chk("R1 underrun after reset", underrun, 0);
      chk("R1 wr_full after reset", wr_full, 0);

      // R2 no output before trigger, R10 disarm
      low_ticks = 1; high_ticks = 5; delay_ticks = 0; arm = 1; src_tick = 1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk("R2 low before trigger", pulse_out, 0);
      end
      start_trig = 1;
      @(negedge clk);
      start_trig = 0;
      @(negedge clk);
      chk("R3 first high", pulse_out, 1);
      @(negedge clk);
      arm = 0;
      @(negedge clk);
      chk("R10 low after disarm", pulse_out, 0);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk("R10 stays low while disarmed", pulse_out, 0);
      end
      arm = 1;
      for (int c = 0; c < 6; c++) begin
         @(negedge clk);
         chk("R10 R2 rearm needs trigger", pulse_out, 0);
      end

      // R3 R4 R5 continuous sweep
      for (int d = 0; d <= 2; d++)
         for (int l = 0; l <= 3; l++)
            for (int h = 0; h <= 3; h++)
               for (int p = 0; p <= 3; p++)
                  run_cont(d, l, h, 1'b0, 1, p, 36);

      // R6 finite sweep
      for (int d = 0; d <= 1; d++)
         for (int l = 1; l <= 2; l++)
            for (int h = 1; h <= 2; h++)
               for (int lim = 1; lim <= 3; lim++)
                  for (int p = 0; p <= 1; p++)
                     run_cont(d, l, h, 1'b1, lim, p, 40);

      // R9 FIFO fill with one extra write
      arm = 0; src_tick = 0; gate = 0; pause_en = 0;
      @(negedge clk);
      qi = '{1, 2, 3, 1, 9}; qa = '{2, 1, 3, 1, 9};
      for (int k = 0; k < 5; k++) begin
         wr_en = 1; wr_idle = CNT_W'(qi[k]); wr_active = CNT_W'(qa[k]);
         @(negedge clk);
         chk("R9 full flag", wr_full, (k >= 3) ? 1 : 0);
      end
      wr_en = 0;

      // R7 R8 buffered run
      buffered_mode = 1; finite_mode = 0; delay_ticks = 2; src_tick = 1;
      arm = 1;
      @(negedge clk);
      start_trig = 1;
      @(negedge clk);
      start_trig = 0;
      e0 = edge_no;
      head = 0; qcnt = 4; hs = 0; he = 0; ur_exp = 0;
      for (int c = 0; c < 60; c++) begin
         sp = (c % 5 == 0) || (c == 1);
         samp_clk = sp;
         if (sp && (edge_no + 1 > e0 + 2) && (edge_no + 1 > he)) begin
            if (qcnt > 0) begin
               hs = edge_no + 1 + qi[head];
               he = hs + qa[head];
               head++; qcnt--;
            end else ur_exp = 1;
         end
         @(negedge clk);
         chk("R7 buffered waveform", pulse_out, (edge_no >= hs && edge_no < he) ? 1 : 0);
         chk("R8 underrun flag", underrun, ur_exp ? 1 : 0);
      end
      samp_clk = 0;
      chk("R9 fifo drained", wr_full, 0);
      arm = 0;
      @(negedge clk);
      chk("R8 underrun cleared by disarm", underrun, 0);
      chk("R1 low when disarmed", pulse_out, 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule